// File: doc/BRIEF.md
# Multi-line receive silo with interrupt timeout

This block is the shared receive buffer of a sixteen-line serial multiplexer. The line receivers, arbitrated outside the block, offer one event per cycle: either a received character with its error flags, or a status event when a line's modem inputs change. Each accepted event becomes one tagged 16-bit entry in a first-in first-out store. The host reads the head entry from `rd_entry` and pulses `rd_pop` to discard it. Bit 15 marks a valid entry, so the host keeps reading until it gets a word with bit 15 clear.

The host interrupt depends on an 8-bit timeout setting and on the fill level. A setting of 1 interrupts on any character. A setting of 0 interrupts only when a status entry arrives or when the store reaches three quarters full. A setting from 2 to 255 waits that many millisecond ticks after the store becomes non-empty. A master reset flushes the store and clears the timeout setting. It then runs a short self-test that leaves exactly eight diagnostic entries in the store. A system reset starts the same sequence.

Top module: `rx_silo`

## Requirements
- R1: While the store is empty, `rd_entry` is all zeros, with bit 15 clear. While it holds entries, `rd_entry` shows the oldest entry, with bit 15 set.
- R2: A character entry has this layout: bit 15 = 1, bit 14 = overrun, bits 13:12 = error kind, bits 11:8 = line number, bits 7:0 = data. The error kind is 00 for no error, 01 for a parity error and 10 for a framing error. A character with both errors is stored with kind 10.
- R3: A status entry has error kind 11 and the line number in bits 11:8. Bit 0 is the diagnostic flag, which is 0 for a modem change. Bit 1 is the current carrier-detect level. Bits 7:2 are zero.
- R4: Entries leave in arrival order. A pop while the store is empty changes nothing.
- R5: An event that arrives while the store holds DEPTH entries is dropped. The next entry that is stored has bit 14 set, and the entries after it have bit 14 clear.
- R6: With timeout setting 1 and `irq_en` high, `irq` rises within two cycles of the store becoming non-empty.
- R7: With timeout setting 0, `irq` rises only after a status entry has been stored since the store was last empty, or once the fill reaches 3*DEPTH/4 entries.
- R8: With a timeout setting T from 2 to 255, `irq` stays low through the first T-1 ticks of `ms_tick` after the store becomes non-empty. It rises within two cycles of the T-th tick.
- R9: Once raised, `irq` stays high until the store is empty or `irq_en` goes low. The tick count restarts each time the store empties.
- R10: A pulse on `mclr_req` flushes the store and clears the timeout setting to 0. `mclr_busy` then stays high until the self-test ends. During that time, events and pops are ignored. The store then holds exactly eight diagnostic entries. Entry i has kind 11, line i, bits 7:4 = i and bits 3:0 = 0001. `selftest_fail` is 0 when the store holds the eight entries.
- R11: Releasing `rst_n` starts the same sequence as R10. `irq` is 0 and `mclr_busy` is 1 right after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_push | input | 1 | Event offered this cycle |
| ev_status | input | 1 | 1: modem status event, 0: character |
| ev_line | input | 4 | Source line number |
| ev_data | input | 8 | Received character |
| ev_perr | input | 1 | Parity error on character |
| ev_ferr | input | 1 | Framing error on character |
| ev_dcd | input | 1 | Carrier-detect level for status event |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rd_pop | input | 1 | Discard the head entry |
| rd_entry | output | 16 | Head entry, bit 15 = valid |
| tmo_wr | input | 1 | Write strobe for the timeout setting |
| tmo_wdata | input | 8 | New timeout setting |
| irq_en | input | 1 | Interrupt enable |
| mclr_req | input | 1 | Start a master reset |
| mclr_busy | output | 1 | Master reset in progress |
| selftest_fail | output | 1 | Self-test failure flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with DEPTH = 16 and MCLR_CYC = 4. At that depth, a full store and the alarm level of 12 are reached within a few dozen pushes. This makes overrun marking and the fill-level interrupt cheap to exercise repeatedly alongside random traffic. The short clearing phase lets master resets be issued in the middle of a test, with events and pops offered while the sequence runs.

// File: rtl/rx_silo_pkg.sv
`timescale 1ns/1ps
// Shared widths, entry layout and entry builders for the receive silo.
// Assumes a 16-bit host word and 16 source lines.
package rx_silo_pkg;
    localparam int ENTRY_W = 16;
    localparam int LINE_W  = 4;
    localparam int DATA_W  = 8;
    localparam int TMO_W   = 8;
    localparam int NDIAG   = 8;

    localparam logic [1:0] KIND_OK     = 2'b00;
    localparam logic [1:0] KIND_PARITY = 2'b01;
    localparam logic [1:0] KIND_FRAME  = 2'b10;
    localparam logic [1:0] KIND_STATUS = 2'b11;

    typedef struct packed {
        logic              valid;
        logic              ovr;
        logic [1:0]        kind;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } silo_entry_t;

    typedef enum logic [1:0] {SEQ_CLEAR, SEQ_LOAD, SEQ_CHECK, SEQ_RUN} seq_state_t;

    // Character entry; framing error outranks parity error.
    function automatic silo_entry_t char_entry(input logic [LINE_W-1:0] line,
                                               input logic [DATA_W-1:0] data,
                                               input logic perr, input logic ferr,
                                               input logic ovr);
        silo_entry_t e;
        e.valid = 1'b1;
        e.ovr   = ovr;
        e.kind  = ferr ? KIND_FRAME : (perr ? KIND_PARITY : KIND_OK);
        e.line  = line;
        e.data  = data;
        return e;
    endfunction

    // Modem change entry: bit1 carrier, bit0 diagnostic flag (0).
    function automatic silo_entry_t stat_entry(input logic [LINE_W-1:0] line,
                                               input logic dcd, input logic ovr);
        silo_entry_t e;
        e.valid = 1'b1;
        e.ovr   = ovr;
        e.kind  = KIND_STATUS;
        e.line  = line;
        e.data  = {6'b0, dcd, 1'b0};
        return e;
    endfunction

    // Diagnostic entry number idx.
    function automatic silo_entry_t diag_entry(input logic [LINE_W-1:0] idx);
        silo_entry_t e;
        e.valid = 1'b1;
        e.ovr   = 1'b0;
        e.kind  = KIND_STATUS;
        e.line  = idx;
        e.data  = {idx, 4'b0001};
        return e;
    endfunction
endpackage

// File: rtl/rx_silo_store.sv
`timescale 1ns/1ps
// Entry store: circular buffer with fill count.
// Assumes DEPTH is a power of two; a push into a full store is refused.
module rx_silo_store
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  silo_entry_t   push_data,
    input  logic          pop,
    output silo_entry_t   head,
    output logic [CW-1:0] fill,
    output logic          full
);
    silo_entry_t   mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Qualify requests against the current fill.
    always_comb begin
        full    = (fill == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (fill != '0);
        head    = mem[rd_ptr];
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(do_push);
            rd_ptr <= rd_ptr + AW'(do_pop);
            fill   <= fill + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
    a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && fill == '0) |=> (fill == '0));
endmodule

// File: rtl/rx_silo_selftest.sv
`timescale 1ns/1ps
// Master-reset sequencer: holds a clear phase, loads the diagnostic
// entries one per cycle, then checks the fill. Assumes the store
// accepts no other pushes while busy is high.
module rx_silo_selftest
    import rx_silo_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int MCLR_CYC = 64,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int TW  = $clog2(MCLR_CYC) + 1,
    localparam int IW  = $clog2(NDIAG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] fill,
    output logic          busy,
    output logic          flush,
    output logic          diag_push,
    output silo_entry_t   diag_data,
    output logic          fail
);
    seq_state_t    state;
    logic [TW-1:0] tcnt;
    logic [IW-1:0] idx;

    // Sequencer state progression.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state <= SEQ_CLEAR;
            tcnt  <= '0;
            idx   <= '0;
            fail  <= 1'b0;
        end else begin
            case (state)
                SEQ_CLEAR: begin
                    if (tcnt == TW'(MCLR_CYC - 1)) state <= SEQ_LOAD;
                    else                           tcnt  <= tcnt + 1'b1;
                end
                SEQ_LOAD: begin
                    idx <= idx + 1'b1;
                    if (idx == IW'(NDIAG - 1)) state <= SEQ_CHECK;
                end
                SEQ_CHECK: begin
                    fail  <= (fill != CW'(NDIAG));
                    state <= SEQ_RUN;
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    // Outputs decoded from the sequencer state.
    always_comb begin
        busy      = (state != SEQ_RUN);
        flush     = (state == SEQ_CLEAR);
        diag_push = (state == SEQ_LOAD);
        diag_data = diag_entry(LINE_W'(idx));
    end

    a_r10_load_order: assert property (@(posedge clk) disable iff (!rst_n || start)
        (state == SEQ_CHECK) |-> $past(state == SEQ_LOAD));
endmodule

// File: rtl/rx_silo_irq.sv
`timescale 1ns/1ps
// Interrupt timing: holds the timeout setting, counts millisecond
// ticks while the store is non-empty and latches the request.
// Assumes ms_tick is a single-cycle pulse.
module rx_silo_irq
    import rx_silo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_wdata,
    input  logic             tmo_clr,
    input  logic             ie,
    input  logic             empty,
    input  logic             alarm,
    input  logic             stat_stored,
    input  logic             ms_tick,
    output logic             irq
);
    logic [TMO_W-1:0] tmo_q, ms_q;
    logic             seen_q, hit;

    // Timeout setting register.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_clr) tmo_q <= '0;
        else if (tmo_wr)       tmo_q <= tmo_wdata;
    end

    // Tick counter since the store became non-empty, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || empty)                ms_q <= '0;
        else if (ms_tick && (&ms_q) == 1'b0) ms_q <= ms_q + 1'b1;
    end

    // Remembers a status entry stored since the last empty state.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_q <= 1'b0;
        else if (stat_stored) seen_q <= 1'b1;
        else if (empty)       seen_q <= 1'b0;
    end

    // Raise conditions per timeout mode.
    always_comb begin
        hit = alarm || seen_q
            || (tmo_q == TMO_W'(1))
            || ((tmo_q >= TMO_W'(2)) && (ms_q >= tmo_q));
    end

    // Latched request, dropped on empty or enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= ie && !empty && (irq || hit);
    end

    a_r9_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !irq);
    a_r9_drained: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !irq);
    a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && !empty && tmo_q == TMO_W'(1)) |=> irq);
endmodule

// File: rtl/rx_silo.sv
`timescale 1ns/1ps
// Receive silo top: formats line events into entries, tracks overrun,
// and ties the store, self-test sequencer and interrupt timer together.
// Assumes one event per cycle from an external receiver arbiter.
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int MCLR_CYC = 64,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int ALARM_LVL = (3 * DEPTH) / 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_push,
    input  logic               ev_status,
    input  logic [LINE_W-1:0]  ev_line,
    input  logic [DATA_W-1:0]  ev_data,
    input  logic               ev_perr,
    input  logic               ev_ferr,
    input  logic               ev_dcd,
    input  logic               ms_tick,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_entry,
    input  logic               tmo_wr,
    input  logic [TMO_W-1:0]   tmo_wdata,
    input  logic               irq_en,
    input  logic               mclr_req,
    output logic               mclr_busy,
    output logic               selftest_fail,
    output logic               irq
);
    silo_entry_t   ev_entry, diag_data, push_data, head;
    logic          accept, push, pop, full, flush, diag_push, stat_stored, ovr_pend;
    logic [CW-1:0] fill;

    // Build the entry for the offered event and pick the store source.
    always_comb begin
        ev_entry    = ev_status ? stat_entry(ev_line, ev_dcd, ovr_pend)
                                : char_entry(ev_line, ev_data, ev_perr, ev_ferr, ovr_pend);
        accept      = ev_push && !mclr_busy;
        push        = mclr_busy ? diag_push : (accept && !full);
        push_data   = mclr_busy ? diag_data : ev_entry;
        stat_stored = push && (push_data.kind == KIND_STATUS);
        pop         = rd_pop && !mclr_busy;
        rd_entry    = (fill != '0) ? head : '0;
    end

    // Overrun marker: set on a dropped event, cleared by the next store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)    ovr_pend <= 1'b0;
        else if (accept && full) ovr_pend <= 1'b1;
        else if (accept)         ovr_pend <= 1'b0;
    end

    rx_silo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_data(push_data), .pop(pop), .head(head), .fill(fill), .full(full)
    );

    rx_silo_selftest #(.DEPTH(DEPTH), .MCLR_CYC(MCLR_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(mclr_req), .fill(fill),
        .busy(mclr_busy), .flush(flush), .diag_push(diag_push),
        .diag_data(diag_data), .fail(selftest_fail)
    );

    rx_silo_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
        .tmo_clr(flush), .ie(irq_en), .empty(fill == '0),
        .alarm(fill >= CW'(ALARM_LVL)), .stat_stored(stat_stored),
        .ms_tick(ms_tick), .irq(irq)
    );

    a_r5_drop_marks: assert property (@(posedge clk) disable iff (!rst_n || mclr_req)
        (ev_push && !mclr_busy && full) |=> ovr_pend);
    a_r10_diag_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mclr_busy) |-> (fill == CW'(NDIAG)));
    a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_entry[ENTRY_W-1] == 1'b0) |-> (fill == '0));
endmodule

// File: tb/sim_rx_silo.sv
`timescale 1ns/1ps
module sim_rx_silo;
    localparam int DEPTH = 16;
    localparam int MCLR  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_push = 0, ev_status = 0, ev_perr = 0, ev_ferr = 0, ev_dcd = 0;
    logic [3:0] ev_line = 0;
    logic [7:0] ev_data = 0;
    logic ms_tick = 0, rd_pop = 0, tmo_wr = 0, irq_en = 0, mclr_req = 0;
    logic [7:0] tmo_wdata = 0;
    logic [15:0] rd_entry;
    logic mclr_busy, selftest_fail, irq;

    int checks = 0, fails = 0;
    logic [15:0] model[$];
    logic ovr_p = 1'b0;

    always #2.5 clk = ~clk;

    rx_silo #(.DEPTH(DEPTH), .MCLR_CYC(MCLR)) u0 (
        .clk, .rst_n, .ev_push, .ev_status, .ev_line, .ev_data, .ev_perr,
        .ev_ferr, .ev_dcd, .ms_tick, .rd_pop, .rd_entry, .tmo_wr, .tmo_wdata,
        .irq_en, .mclr_req, .mclr_busy, .selftest_fail, .irq
    );

    function automatic logic [15:0] exp_entry(input logic st, input logic [3:0] ln,
        input logic [7:0] d, input logic pe, input logic fe, input logic dcd, input logic ov);
        if (st) return {1'b1, ov, 2'b11, ln, 6'b0, dcd, 1'b0};
        return {1'b1, ov, fe ? 2'b10 : (pe ? 2'b01 : 2'b00), ln, d};
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_ev(input logic st, input logic [3:0] ln, input logic [7:0] d,
                           input logic pe, input logic fe, input logic dcd, input logic ignored);
        ev_push = 1; ev_status = st; ev_line = ln; ev_data = d;
        ev_perr = pe; ev_ferr = fe; ev_dcd = dcd;
        @(negedge clk);
        ev_push = 0;
        if (!ignored) begin
            if (model.size() < DEPTH) begin
                model.push_back(exp_entry(st, ln, d, pe, fe, dcd, ovr_p));
                ovr_p = 1'b0;
            end else ovr_p = 1'b1;
        end
    endtask

    task automatic push_rand(input logic allow_stat);
        logic st;
        st = allow_stat && ($urandom_range(0, 3) == 0);
        push_ev(st, 4'($urandom_range(0, 15)), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    endtask

    task automatic pop_chk(input string req);
        logic [15:0] e;
        e = (model.size() > 0) ? model[0] : 16'h0000;
        check(rd_entry === e, req, rd_entry, e);
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        if (model.size() > 0) void'(model.pop_front());
    endtask

    task automatic drain(input string req);
        while (model.size() > 0) pop_chk(req);
    endtask

    task automatic tick();
        ms_tick = 1; @(negedge clk); ms_tick = 0; @(negedge clk);
    endtask

    task automatic set_tmo(input logic [7:0] v);
        tmo_wr = 1; tmo_wdata = v; @(negedge clk); tmo_wr = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && mclr_busy; i++) @(negedge clk);
    endtask

    task automatic expect_diag(input string req);
        model.delete();
        ovr_p = 1'b0;
        for (int i = 0; i < 8; i++) model.push_back({4'b1011, 4'(i), 4'(i), 4'b0001});
        check(selftest_fail === 1'b0, req, 16'(selftest_fail), 16'h0);
        drain(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: state right after reset release
        check(mclr_busy === 1'b1, "R11", 16'(mclr_busy), 16'h1);
        check(irq === 1'b0, "R11", 16'(irq), 16'h0);
        wait_idle();
        expect_diag("R11");
        // R1: empty word; R4: pop on empty is harmless
        check(rd_entry === 16'h0, "R1", rd_entry, 16'h0);
        pop_chk("R4");
        check(rd_entry === 16'h0, "R4", rd_entry, 16'h0);

        // R2, R3, R4: random traffic with ordered drain
        for (int r = 0; r < 40; r++) begin
            int n = $urandom_range(1, 12);
            for (int k = 0; k < n; k++) push_rand(1'b1);
            drain("R2_R3_R4");
        end
        // R2: both errors map to framing kind
        push_ev(0, 4'h9, 8'hA5, 1, 1, 0, 0);
        check(rd_entry === 16'hA9A5, "R2", rd_entry, 16'hA9A5);
        drain("R2");
        // R3: modem change with carrier high
        push_ev(1, 4'hF, 8'hFF, 1, 1, 1, 0);
        check(rd_entry === 16'hBF02, "R3", rd_entry, 16'hBF02);
        drain("R3");

        // R5: overrun marking
        for (int k = 0; k < DEPTH + 3; k++) push_rand(1'b1);
        pop_chk("R5"); pop_chk("R5");
        push_ev(0, 4'h3, 8'h11, 0, 0, 0, 0);
        push_ev(0, 4'h4, 8'h22, 0, 0, 0, 0);
        for (int k = 0; k < DEPTH - 2; k++) pop_chk("R5");
        check(rd_entry === 16'hC311, "R5", rd_entry, 16'hC311);
        pop_chk("R5");
        check(rd_entry === 16'h8422, "R5", rd_entry, 16'h8422);
        drain("R5");

        // R6: immediate mode, R9: drop on empty
        irq_en = 1;
        set_tmo(8'd1);
        push_ev(0, 4'h1, 8'h31, 0, 0, 0, 0);
        @(negedge clk);
        check(irq === 1'b1, "R6", 16'(irq), 16'h1);
        drain("R9");
        @(negedge clk);
        check(irq === 1'b0, "R9", 16'(irq), 16'h0);

        // R7: polled mode
        set_tmo(8'd0);
        push_ev(0, 4'h2, 8'h40, 0, 0, 0, 0);
        repeat (3) tick();
        check(irq === 1'b0, "R7", 16'(irq), 16'h0);
        for (int k = 0; k < 10; k++) push_rand(1'b0);
        @(negedge clk);
        check(irq === 1'b0, "R7", 16'(irq), 16'h0);
        push_rand(1'b0);
        @(negedge clk);
        check(irq === 1'b1, "R7", 16'(irq), 16'h1);
        drain("R7");
        push_ev(0, 4'h5, 8'h50, 0, 0, 0, 0);
        @(negedge clk);
        check(irq === 1'b0, "R7", 16'(irq), 16'h0);
        push_ev(1, 4'h5, 8'h00, 0, 0, 1, 0);
        @(negedge clk);
        check(irq === 1'b1, "R7", 16'(irq), 16'h1);
        drain("R7");

        // R8: tick delay, R9: enable and restart
        set_tmo(8'd5);
        push_ev(0, 4'h6, 8'h60, 0, 0, 0, 0);
        repeat (4) tick();
        check(irq === 1'b0, "R8", 16'(irq), 16'h0);
        tick();
        @(negedge clk);
        check(irq === 1'b1, "R8", 16'(irq), 16'h1);
        irq_en = 0;
        @(negedge clk); @(negedge clk);
        check(irq === 1'b0, "R9", 16'(irq), 16'h0);
        irq_en = 1;
        @(negedge clk); @(negedge clk);
        check(irq === 1'b1, "R9", 16'(irq), 16'h1);
        drain("R9");
        push_ev(0, 4'h7, 8'h70, 0, 0, 0, 0);
        repeat (4) tick();
        check(irq === 1'b0, "R9", 16'(irq), 16'h0);
        drain("R9");

        // R10: master reset with traffic offered while busy
        irq_en = 0;
        push_rand(1'b1); push_rand(1'b1);
        mclr_req = 1; @(negedge clk); mclr_req = 0;
        check(mclr_busy === 1'b1, "R10", 16'(mclr_busy), 16'h1);
        push_ev(0, 4'h8, 8'h80, 0, 0, 0, 1);
        rd_pop = 1; @(negedge clk); rd_pop = 0;
        push_ev(1, 4'h8, 8'h00, 0, 0, 1, 1);
        wait_idle();
        expect_diag("R10");
        // R10: timeout setting cleared to polled mode
        irq_en = 1;
        push_ev(0, 4'hA, 8'h90, 0, 0, 0, 0);
        repeat (8) tick();
        check(irq === 1'b0, "R10", 16'(irq), 16'h0);
        drain("R10");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule